// File: doc/BRIEF.md
# Pixel Unpacker with Palette Lookup

This block sits between a frame-buffer word source and a display pixel pipeline. Producers push 64-bit words into a 16-word input queue. The block cuts each word into pixels at a colour depth chosen by a mode input. At 1, 2, 4 and 8 bits per pixel, the pixel value is an index into a 256-entry colour palette. At 16 and 24 bits per pixel, the value is already a colour and skips the palette. Pixels leave one per accepted cycle on a 24-bit output stream with valid/ready flow control.

The palette is held as 128 words of 32 bits, each word carrying two 16-bit colours. Software or a loader fills it through a simple write port. The input words form one continuous bit stream, so a 24-bit pixel may begin in one word and end in the next. A mode bit chooses whether pixels are taken from the low end or the high end of each word first.

Top module: `pix_unpack`

## Requirements
- R1: A word on `inData` with `inValid` high is queued at the clock edge when `fifoFull` is low, and is dropped when `fifoFull` is high. The queue holds 16 words. `fifoEmpty` is high exactly when no word is queued.
- R2: `depthSel` selects the depth: 0=1, 1=2, 2=4, 3=8, 4=16 and 5=24 bits per pixel. The words form one continuous bit stream in push order, and pixel i occupies stream bits i*bpp to i*bpp+bpp-1.
- R3: With `bigEnd` low, stream bit s is bit s mod 64 of word s/64, and the first stream bit of a pixel is its least significant bit.
- R4: With `bigEnd` high, stream bit s is bit 63-(s mod 64) of word s/64, and the first stream bit of a pixel is its most significant bit.
- R5: At depths 0 to 3 the pixel value, zero-extended to 8 bits, is a palette index. Palette word index/2 is read, and its bits [15:0] are used for an even index and bits [31:16] for an odd one.
- R6: With `palWe` high, `palData` is written to palette word `palAddr` at the clock edge. Every pixel taken after that edge uses the new contents, even while a stream is running.
- R7: At depth 4 the 16-bit pixel value is used directly as the colour, without a palette lookup.
- R8: At depth 5 the 24-bit pixel value appears unchanged on `outPixel`, including pixels that straddle two words.
- R9: A 16-bit colour (red [15:11], green [10:5], blue [4:0]) is output as red in [23:16], green in [15:8] and blue in [7:0]. Each field is left-aligned, and its top bits are repeated into the bits left free below it.
- R10: While `outValid` is high and `outReady` is low, `outValid` and `outPixel` hold. Each pixel appears exactly once, in stream order.
- R11: After reset, `outValid` is low, `fifoEmpty` is high and `fifoFull` is low. The palette contents are undefined until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| inValid | input | 1 | Push strobe for the input word |
| inData | input | 64 | Frame-buffer word |
| fifoFull | output | 1 | Input queue full |
| fifoEmpty | output | 1 | Input queue empty |
| palWe | input | 1 | Palette write strobe |
| palAddr | input | 7 | Palette word address |
| palData | input | 32 | Two palette colours; the even entry is in the low half |
| depthSel | input | 3 | Colour depth code |
| bigEnd | input | 1 | Pixel order within a word |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Output pixel accepted |
| outPixel | output | 24 | Pixel colour, 8 bits each of red, green and blue |

## Verification
The assertions assume that `depthSel` and `bigEnd` stay constant while any word or pixel is pending. They also assume that each stream ends on a whole pixel, so a 24-bit stream is a multiple of three words. The bench changes mode only after the queue is empty and `outValid` has dropped. Its random tests size each stream so that no bits are left over. Ready and push activity are randomised inside these limits, and a directed test overfills the queue to show that the extra words are dropped.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int WORD_W = 64;
  localparam int PIX_W  = 24;
  localparam int COL_W  = 16;
  localparam int CNT_W  = 7;

  typedef enum logic [2:0] {
    DEP_1 = 3'd0, DEP_2 = 3'd1, DEP_4 = 3'd2,
    DEP_8 = 3'd3, DEP_16 = 3'd4, DEP_24 = 3'd5
  } depth_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             take;     // capture a pixel into the output register
    logic             load;     // pop the head word into the window
    logic [CNT_W-1:0] placeAt;  // bits still valid after this cycle's take
    logic [4:0]       bpp;
  } strobe_t;

  function automatic logic [4:0] bppOf(input logic [2:0] d);
    case (d)
      DEP_1:   return 5'd1;
      DEP_2:   return 5'd2;
      DEP_4:   return 5'd4;
      DEP_16:  return 5'd16;
      DEP_24:  return 5'd24;
      default: return 5'd8;
    endcase
  endfunction
endpackage

// File: rtl/pix_unpack_ctrl.sv
module pix_unpack_ctrl
  import pix_unpack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] depthSel,
  input  logic       fifoEmpty,
  input  logic       outReady,
  output logic       outValid,
  output strobe_t    st
);
  logic [CNT_W-1:0] cnt, cntAfter, bppW;
  logic             take, load;

  always_comb begin
    bppW     = CNT_W'(bppOf(depthSel));
    take     = (cnt >= bppW) && (!outValid || outReady);
    cntAfter = take ? cnt - bppW : cnt;
    load     = !fifoEmpty && (cntAfter < bppW);
    st       = '{take: take, load: load, placeAt: cntAfter, bpp: bppOf(depthSel)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      outValid <= 1'b0;
    end else begin
      cnt <= cntAfter + (load ? CNT_W'(WORD_W) : '0);
      if (take)          outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_unpack_dp.sv
module pix_unpack_dp
  import pix_unpack_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int PAL_WORDS  = 128,
  parameter int PAL_AW     = $clog2(PAL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  input  logic              palWe,
  input  logic [PAL_AW-1:0] palAddr,
  input  logic [2*COL_W-1:0] palData,
  input  logic [2:0]        depthSel,
  input  logic              bigEnd,
  input  strobe_t           st,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic [PIX_W-1:0]  outPixel
);
  localparam int FAW   = $clog2(FIFO_DEPTH);
  localparam int WIN_W = WORD_W + PIX_W;

  // input queue
  logic [WORD_W-1:0] fifoMem [FIFO_DEPTH];
  logic [FAW:0]      wrPtr, rdPtr;
  logic              pushOk;
  logic [WORD_W-1:0] headWord;

  assign fifoEmpty = (wrPtr == rdPtr);
  assign fifoFull  = ((wrPtr - rdPtr) == (FAW+1)'(FIFO_DEPTH));
  assign pushOk    = inValid && !fifoFull;
  assign headWord  = fifoMem[rdPtr[FAW-1:0]];

  always_ff @(posedge clk) if (pushOk) fifoMem[wrPtr[FAW-1:0]] <= inData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (pushOk)  wrPtr <= wrPtr + 1'b1;
      if (st.load) rdPtr <= rdPtr + 1'b1;
    end
  end

  // palette: two colours per word
  logic [2*COL_W-1:0] palMem [PAL_WORDS];
  always_ff @(posedge clk) if (palWe) palMem[palAddr] <= palData;

  // bit window: valid bits at the low end (little) or high end (big)
  logic [WIN_W-1:0] win, shifted, placed;
  logic [4:0]       shamt;

  always_comb begin
    shamt = st.take ? st.bpp : 5'd0;
    if (st.placeAt == '0)  shifted = '0;
    else if (bigEnd)       shifted = win << shamt;
    else                   shifted = win >> shamt;
    if (bigEnd) placed = WIN_W'(headWord) << (CNT_W'(PIX_W) - st.placeAt);
    else        placed = WIN_W'(headWord) << st.placeAt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else        win <= st.load ? (shifted | placed) : shifted;
  end

  // pixel extraction and colour formation
  logic [PIX_W-1:0]   mask, raw, pixNext;
  logic [PAL_AW:0]    idx;
  logic [2*COL_W-1:0] palWord;
  logic [COL_W-1:0]   col;

  always_comb begin
    mask = (PIX_W'(1) << st.bpp) - PIX_W'(1);
    if (bigEnd) raw = win[WIN_W-1 -: PIX_W] >> (5'(PIX_W) - st.bpp);
    else        raw = win[PIX_W-1:0] & mask;
    idx     = raw[PAL_AW:0];
    palWord = palMem[idx[PAL_AW:1]];
    col     = (depthSel == DEP_16) ? raw[COL_W-1:0]
            : (idx[0] ? palWord[2*COL_W-1:COL_W] : palWord[COL_W-1:0]);
    if (depthSel == DEP_24) pixNext = raw;
    else pixNext = {col[15:11], col[15:13], col[10:5], col[10:9], col[4:0], col[4:2]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       outPixel <= '0;
    else if (st.take) outPixel <= pixNext;
  end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int PAL_WORDS  = 128,
  parameter int PAL_AW     = $clog2(PAL_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [63:0] inData,
  output logic        fifoFull,
  output logic        fifoEmpty,
  input  logic        palWe,
  input  logic [PAL_AW-1:0] palAddr,
  input  logic [31:0] palData,
  input  logic [2:0]  depthSel,
  input  logic        bigEnd,
  output logic        outValid,
  input  logic        outReady,
  output logic [23:0] outPixel
);
  strobe_t st;

  pix_unpack_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .depthSel(depthSel), .fifoEmpty(fifoEmpty),
    .outReady(outReady), .outValid(outValid), .st(st)
  );

  pix_unpack_dp #(.FIFO_DEPTH(FIFO_DEPTH), .PAL_WORDS(PAL_WORDS), .PAL_AW(PAL_AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData),
    .palWe(palWe), .palAddr(palAddr), .palData(palData),
    .depthSel(depthSel), .bigEnd(bigEnd), .st(st),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .outPixel(outPixel)
  );
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fifoFull,
  input logic        fifoEmpty,
  input logic        outValid,
  input logic        outReady,
  input logic [23:0] outPixel,
  input logic [2:0]  depthSel
);
  // R1: the queue can never be both full and empty
  p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifoFull && fifoEmpty));

  // R10: a stalled pixel stays valid
  p_hold_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid);

  // R10: a stalled pixel keeps its value
  p_hold_pixel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> $stable(outPixel));

  // R9: widened colours repeat the top bits of each field in its low bits
  p_widen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && depthSel < 3'd5 |->
      outPixel[18:16] == outPixel[23:21] && outPixel[9:8] == outPixel[15:14] &&
      outPixel[2:0] == outPixel[7:5]);
endmodule

bind pix_unpack pix_unpack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
  .outValid(outValid), .outReady(outReady), .outPixel(outPixel), .depthSel(depthSel)
);

// File: tb/sim_pix_unpack.sv
module sim_pix_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inData = '0;
  logic        fifoFull, fifoEmpty;
  logic        palWe = 1'b0;
  logic [6:0]  palAddr = '0;
  logic [31:0] palData = '0;
  logic [2:0]  depthSel = 3'd0;
  logic        bigEnd = 1'b0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [23:0] outPixel;

  int checks = 0;
  int errors = 0;
  logic [31:0] palM [0:127];
  logic [63:0] words [0:31];

  always #5 clk = ~clk;

  pix_unpack u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .palWe(palWe), .palAddr(palAddr),
    .palData(palData), .depthSel(depthSel), .bigEnd(bigEnd), .outValid(outValid),
    .outReady(outReady), .outPixel(outPixel)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bitsOf(input int d);
    int t[6] = '{1, 2, 4, 8, 16, 24};
    return (d >= 0 && d < 6) ? t[d] : 8;
  endfunction

  function automatic logic [23:0] grow(input logic [15:0] c);
    logic [4:0] r = c[15:11];
    logic [5:0] g = c[10:5];
    logic [4:0] b = c[4:0];
    return {r, r[4:2], g, g[5:4], b, b[4:2]};
  endfunction

  function automatic logic [23:0] expPix(input int i, input int d, input bit be);
    int n = bitsOf(d);
    logic [23:0] v = '0;
    logic [15:0] c;
    for (int j = 0; j < n; j++) begin
      int s = i * n + j;
      if (be) v = {v[22:0], words[s / 64][63 - (s % 64)]};
      else    v[j] = words[s / 64][s % 64];
    end
    if (d == 5) return v;
    if (d == 4) c = v[15:0];
    else        c = v[0] ? palM[v[7:1]][31:16] : palM[v[7:1]][15:0];
    return grow(c);
  endfunction

  // runs one stream of nw words (already pushed if pre) and checks every pixel
  task automatic runStream(input int nw, input int d, input bit be, input bit pre);
    int npix = nw * 64 / bitsOf(d);
    int pushIdx = pre ? nw : 0;
    int popIdx = 0;
    int guard = 0;
    bit holdPend = 0;
    logic [23:0] holdVal = '0;
    string tag;
    if (d == 5)      tag = be ? "R2/R4/R8" : "R2/R3/R8";
    else if (d == 4) tag = be ? "R2/R4/R7/R9" : "R2/R3/R7/R9";
    else             tag = be ? "R2/R4/R5/R9" : "R2/R3/R5/R9";
    @(negedge clk);
    depthSel = 3'(d);
    bigEnd = be;
    while (popIdx < npix && guard < 20000) begin
      bit rdy;
      @(negedge clk);
      guard++;
      rdy = ($urandom % 4) != 0;
      if (holdPend) chk(outValid && outPixel == holdVal, "R10 hold", {39'd0, outValid, outPixel}, {39'd1, holdVal});
      holdPend = 0;
      if (outValid && rdy) begin
        chk(outPixel == expPix(popIdx, d, be), tag, outPixel, expPix(popIdx, d, be));
        popIdx++;
      end else if (outValid) begin
        holdPend = 1;
        holdVal = outPixel;
      end
      outReady = rdy;
      if (pushIdx < nw && !fifoFull && ($urandom % 2) == 0) begin
        inValid = 1'b1;
        inData = words[pushIdx];
        pushIdx++;
      end else begin
        inValid = 1'b0;
      end
    end
    chk(popIdx == npix, "R10 count", 64'(popIdx), 64'(npix));
    @(negedge clk);
    outReady = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    chk(!outValid && fifoEmpty, "R10 no extra pixel", {outValid, fifoEmpty}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] newWord;
    logic [23:0] oldPix, newPix;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!outValid && fifoEmpty && !fifoFull, "R11 reset", {outValid, fifoEmpty, fifoFull}, 3'b010);

    // fill the palette
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      palWe = 1'b1;
      palAddr = 7'(k);
      palData = $urandom;
      palM[k] = palData;
    end
    @(negedge clk);
    palWe = 1'b0;

    // random streams in every depth and order
    for (int d = 0; d < 6; d++) begin
      for (int be = 0; be < 2; be++) begin
        int nw = (d == 5) ? 3 * (1 + $urandom % 3) : 1 + $urandom % 6;
        for (int w = 0; w < nw; w++) words[w] = {$urandom, $urandom};
        runStream(nw, d, be[0], 1'b0);
      end
    end

    // directed 24 bpp straddle pattern
    words[0] = 64'h0011_2233_4455_6677;
    words[1] = 64'h8899_AABB_CCDD_EEFF;
    words[2] = 64'h0123_4567_89AB_CDEF;
    runStream(3, 5, 1'b0, 1'b0);
    runStream(3, 5, 1'b1, 1'b0);

    // overfill: 20 pushes with the output stalled, only 17 may survive
    for (int w = 0; w < 20; w++) words[w] = {$urandom, $urandom};
    @(negedge clk);
    depthSel = 3'd4;
    bigEnd = 1'b0;
    outReady = 1'b0;
    for (int w = 0; w < 20; w++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = words[w];
    end
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    chk(fifoFull && !fifoEmpty, "R1 full", {fifoFull, fifoEmpty}, 2'b10);
    runStream(17, 4, 1'b0, 1'b1);
    chk(fifoEmpty && !fifoFull, "R1 drained", {fifoEmpty, fifoFull}, 2'b10);

    // palette rewrite while a stream is stalled
    @(negedge clk);
    depthSel = 3'd3;
    bigEnd = 1'b0;
    inValid = 1'b1;
    inData = {8{8'h05}};
    @(negedge clk);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    oldPix = grow(palM[2][31:16]);
    chk(outValid && outPixel == oldPix, "R5/R6 before write", outPixel, oldPix);
    newWord = palM[2] ^ 32'hA5A5_5A5A;
    palWe = 1'b1;
    palAddr = 7'd2;
    palData = newWord;
    @(negedge clk);
    palWe = 1'b0;
    palM[2] = newWord;
    newPix = grow(newWord[31:16]);
    chk(outValid && outPixel == oldPix, "R10 held across write", outPixel, oldPix);
    outReady = 1'b1;
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      chk(outValid && outPixel == newPix, "R6 after write", outPixel, newPix);
    end
    @(negedge clk);
    outReady = 1'b0;
    chk(!outValid, "R10 stream end", 64'(outValid), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule